// File: doc/BRIEF.md
# DMA event capture and prioritizer

This block watches a bank of asynchronous event lines on behalf of a DMA transfer engine. Each line passes through a synchronizer. The block then detects either a rising or a falling edge on it, as software selects per line. A detected edge sets a sticky flag. The flag is set whether or not the event is enabled at that moment.

Flags that are also enabled are split into two groups, an urgent group and a normal group. Each group offers one event to the transfer engine through a valid/ready pair. When the engine accepts an event, its flag clears. Software configures the block through a small word-addressed register port. The port offers:
- set and clear registers for the enables;
- set and clear registers for the group assignment;
- a polarity register;
- read-only views of the flags and of the synchronized line levels;
- write-one-to-clear FIFO status and completion registers, which stub inputs set;
- a software trigger register, where any bit that changes value fires that event;
- a summary status word.

Top module: `evtCaptureTop`

## Requirements
- R1: Bit n of the polarity register (address 0) selects the active edge of line n: 0 means rising and 1 means falling. An edge of the other direction sets no flag. After reset every bit is 0.
- R2: A change on an input line sets its flag on the third rising clock edge after the change, counting the synchronizer and the edge detector. The matching valid output rises after that same edge and not before it.
- R3: Writing 1 to a bit at address 1 enables that event. Writing 1 to a bit at address 2 disables it. Writing 0 to either address changes nothing. Both addresses read back the enable mask.
- R4: Writing 1 to a bit at address 3 moves that event into the urgent group, and writing 1 at address 4 moves it into the normal group. Writing 0 changes nothing. Address 3 reads the urgent mask and address 4 reads its complement. After reset all events are in the normal group.
- R5: A flag is recorded even while its event is disabled, and it is visible at address 5. A disabled flagged event is not offered downstream.
- R6: Within each group, the lowest-numbered event that is both flagged and enabled is offered (hiId/loId). loValid stays low while any enabled urgent flag is pending.
- R7: An accepted handshake (valid and ready high at a clock edge) clears that event's flag. If a new edge for the same event arrives in the same cycle, the flag stays set.
- R8: Addresses 6, 7, 8 and 9 return the synchronized levels of lines 7..0, 15..8, 23..16 and 31..24 in bits 7..0.
- R9: FIFO status registers at addresses 10 and 11 are set by fifoSet0 and fifoSet1. Writing 1 clears a bit and writing 0 leaves it unchanged. If a set and a clear hit the same bit in the same cycle, the set wins.
- R10: Completion registers at addresses 12 and 13 are set by cplSet0 and cplSet1 and are cleared by writing 1, in the same way as R9.
- R11: At address 14, every bit whose written value differs from the stored value sets the flag of that event at the write edge. The register reads back the last value written.
- R12: Address 15 reads the completion register 0 bits in bits 7..0 and the completion register 1 bits in bits 15..8. Bit 16 is 1 while hiValid or loValid is high.
- R13: Reset clears all enables, flags, polarity bits, trigger bits and status bits, and both valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtIn | input | 32 | Asynchronous event lines |
| busAddr | input | 4 | Register word address |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Register read data, combinational from busAddr |
| fifoSet0 | input | 8 | Stub set bits for FIFO status register 0 |
| fifoSet1 | input | 8 | Stub set bits for FIFO status register 1 |
| cplSet0 | input | 8 | Stub set bits for completion register 0 |
| cplSet1 | input | 8 | Stub set bits for completion register 1 |
| hiValid | output | 1 | An urgent event is offered |
| hiId | output | 5 | Number of the offered urgent event |
| hiReady | input | 1 | Engine accepts the urgent event |
| loValid | output | 1 | A normal event is offered |
| loId | output | 5 | Number of the offered normal event |
| loReady | input | 1 | Engine accepts the normal event |

## Verification
A lost or stuck flag shows at the ports in one of two ways. The valid and id outputs turn out wrong three edges after a line change, or the cycle after a trigger write. A flag read also exposes it at once. A corrupted enable, group or polarity bit surfaces on the very next register read, or as the wrong event number on hiId or loId in the same cycle the flag becomes pending. A broken clear path leaves a flag standing after the accepting edge, so the next sample still shows valid high with the same id.

// File: rtl/evtPkg.sv
package evtPkg;

  localparam int unsigned ADDR_W = 4;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned LANE_W = 8;

  // group index used by the two pickers
  localparam int unsigned GRP_URG = 0;
  localparam int unsigned GRP_NRM = 1;

  typedef enum logic [ADDR_W-1:0] {
    REG_POL    = 4'd0,
    REG_EN_SET = 4'd1,
    REG_EN_CLR = 4'd2,
    REG_GRP_HI = 4'd3,
    REG_GRP_LO = 4'd4,
    REG_FLAG   = 4'd5,
    REG_LVL0   = 4'd6,
    REG_LVL1   = 4'd7,
    REG_LVL2   = 4'd8,
    REG_LVL3   = 4'd9,
    REG_FIFO0  = 4'd10,
    REG_FIFO1  = 4'd11,
    REG_CPL0   = 4'd12,
    REG_CPL1   = 4'd13,
    REG_TRIG   = 4'd14,
    REG_STATUS = 4'd15
  } regAddr_e;

  // write strobes from control into the event datapath
  typedef struct packed {
    logic polWr;
    logic enSet;
    logic enClr;
    logic grpHiWr;
    logic grpLoWr;
    logic trigWr;
  } evtStb_t;

endpackage

// File: rtl/evtPick.sv
module evtPick #(
  parameter int unsigned N  = 32,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  req,
  output logic          valid,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  grant
);

  always_comb begin
    valid = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    grant = '0;
    if (valid) grant[idx] = 1'b1;
  end

  // R6: the chosen request is real and no lower-numbered request is pending
  assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    valid |-> (req[idx] && ((req & (grant - N'(1))) == '0)));

endmodule

// File: rtl/evtW1cReg.sv
module evtW1cReg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] setIn,
  input  logic         clrStb,
  input  logic [W-1:0] clrData,
  output logic [W-1:0] q
);

  logic [W-1:0] clrMask;

  assign clrMask = clrStb ? clrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= '0;
    else       q <= (q & ~clrMask) | setIn;
  end

  // R9: a set bit is present on the next cycle, even against a clear
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|setIn) |=> ((q & $past(setIn)) == $past(setIn)));

  // R10: writing ones with no concurrent set clears those bits
  assert_w1c_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (clrStb && setIn == '0) |=> ((q & $past(clrData)) == '0));

endmodule

// File: rtl/evtDatapath.sv
module evtDatapath
  import evtPkg::*;
#(
  parameter int unsigned NUM_EVT     = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IW          = $clog2(NUM_EVT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtIn,
  input  evtStb_t            stb,
  input  logic [NUM_EVT-1:0] wrData,
  input  logic               hiReady,
  input  logic               loReady,
  output logic               hiValid,
  output logic [IW-1:0]      hiId,
  output logic               loValid,
  output logic [IW-1:0]      loId,
  output logic [NUM_EVT-1:0] polQ,
  output logic [NUM_EVT-1:0] enQ,
  output logic [NUM_EVT-1:0] grpHiQ,
  output logic [NUM_EVT-1:0] trigQ,
  output logic [NUM_EVT-1:0] flagQ,
  output logic [NUM_EVT-1:0] levelQ,
  output logic               busy
);

  logic [NUM_EVT-1:0] syncChain [SYNC_STAGES];
  logic [NUM_EVT-1:0] prevLvl;
  logic [NUM_EVT-1:0] hwEdge, swEdge, edgeMask;
  logic [NUM_EVT-1:0] pend, clearMask, flagNext;

  logic [NUM_EVT-1:0] grpReq   [2];
  logic               grpValid [2];
  logic [IW-1:0]      grpIdx   [2];
  logic [NUM_EVT-1:0] grpGrant [2];
  logic               hiFire, loFire;

  assign levelQ = syncChain[SYNC_STAGES-1];

  // per-line edge of the selected direction
  assign hwEdge = (~polQ & levelQ & ~prevLvl) | (polQ & ~levelQ & prevLvl);
  assign swEdge = stb.trigWr ? (wrData ^ trigQ) : '0;
  assign edgeMask = hwEdge | swEdge;

  assign pend = flagQ & enQ;
  assign grpReq[GRP_URG] = pend & grpHiQ;
  assign grpReq[GRP_NRM] = pend & ~grpHiQ;

  for (genvar g = 0; g < 2; g++) begin : gPick
    evtPick #(.N(NUM_EVT), .IW(IW)) i_pick (
      .clk   (clk),
      .rstN  (rstN),
      .req   (grpReq[g]),
      .valid (grpValid[g]),
      .idx   (grpIdx[g]),
      .grant (grpGrant[g])
    );
  end

  assign hiValid = grpValid[GRP_URG];
  assign hiId    = grpIdx[GRP_URG];
  assign loValid = grpValid[GRP_NRM] & ~grpValid[GRP_URG];
  assign loId    = grpIdx[GRP_NRM];
  assign busy    = hiValid | loValid;

  assign hiFire = hiValid & hiReady;
  assign loFire = loValid & loReady;
  assign clearMask = (hiFire ? grpGrant[GRP_URG] : '0) | (loFire ? grpGrant[GRP_NRM] : '0);
  assign flagNext  = (flagQ & ~clearMask) | edgeMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '{default: '0};
      prevLvl   <= '0;
      polQ      <= '0;
      enQ       <= '0;
      grpHiQ    <= '0;
      trigQ     <= '0;
      flagQ     <= '0;
    end else begin
      syncChain[0] <= evtIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncChain[s] <= syncChain[s-1];
      prevLvl <= levelQ;
      if (stb.polWr) polQ <= wrData;
      if (stb.enSet)      enQ <= enQ | wrData;
      else if (stb.enClr) enQ <= enQ & ~wrData;
      if (stb.grpHiWr)      grpHiQ <= grpHiQ | wrData;
      else if (stb.grpLoWr) grpHiQ <= grpHiQ & ~wrData;
      if (stb.trigWr) trigQ <= wrData;
      flagQ <= flagNext;
    end
  end

  // R6: the normal group never drives while an urgent event waits
  assert_urgent_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    loValid |-> (grpReq[GRP_URG] == '0));

  // R7: every edge leaves its flag set, even on an accepting cycle (also R5)
  assert_edge_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|edgeMask) |=> ((flagQ & $past(edgeMask)) == $past(edgeMask)));

  // R7: acceptance without a new edge drops the flag
  assert_accept_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (hiFire && ((grpGrant[GRP_URG] & edgeMask) == '0))
      |=> ((flagQ & $past(grpGrant[GRP_URG])) == '0));

  // R3: enabling bits takes effect on the next cycle
  assert_enable_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.enSet |=> ((enQ & $past(wrData)) == $past(wrData)));

endmodule

// File: rtl/evtCtrl.sv
module evtCtrl
  import evtPkg::*;
#(
  parameter int unsigned NUM_EVT = 32,
  parameter int unsigned FIFO_W  = 8,
  parameter int unsigned CPL_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [BUS_W-1:0]   busWrData,
  output logic [BUS_W-1:0]   busRdData,
  input  logic [FIFO_W-1:0]  fifoSet0,
  input  logic [FIFO_W-1:0]  fifoSet1,
  input  logic [CPL_W-1:0]   cplSet0,
  input  logic [CPL_W-1:0]   cplSet1,
  output evtStb_t            stb,
  input  logic [NUM_EVT-1:0] polQ,
  input  logic [NUM_EVT-1:0] enQ,
  input  logic [NUM_EVT-1:0] grpHiQ,
  input  logic [NUM_EVT-1:0] trigQ,
  input  logic [NUM_EVT-1:0] flagQ,
  input  logic [NUM_EVT-1:0] levelQ,
  input  logic               busy
);

  localparam int unsigned NUM_LANE = NUM_EVT / LANE_W;

  logic [FIFO_W-1:0] fifoSet [2];
  logic [FIFO_W-1:0] fifoQ   [2];
  logic [CPL_W-1:0]  cplSet  [2];
  logic [CPL_W-1:0]  cplQ    [2];

  assign fifoSet[0] = fifoSet0;
  assign fifoSet[1] = fifoSet1;
  assign cplSet[0]  = cplSet0;
  assign cplSet[1]  = cplSet1;

  always_comb begin
    stb         = '0;
    stb.polWr   = busWrEn && (busAddr == REG_POL);
    stb.enSet   = busWrEn && (busAddr == REG_EN_SET);
    stb.enClr   = busWrEn && (busAddr == REG_EN_CLR);
    stb.grpHiWr = busWrEn && (busAddr == REG_GRP_HI);
    stb.grpLoWr = busWrEn && (busAddr == REG_GRP_LO);
    stb.trigWr  = busWrEn && (busAddr == REG_TRIG);
  end

  for (genvar f = 0; f < 2; f++) begin : gFifo
    evtW1cReg #(.W(FIFO_W)) i_fifoReg (
      .clk     (clk),
      .rstN    (rstN),
      .setIn   (fifoSet[f]),
      .clrStb  (busWrEn && (busAddr == ADDR_W'(int'(REG_FIFO0) + f))),
      .clrData (busWrData[FIFO_W-1:0]),
      .q       (fifoQ[f])
    );
  end

  for (genvar c = 0; c < 2; c++) begin : gCpl
    evtW1cReg #(.W(CPL_W)) i_cplReg (
      .clk     (clk),
      .rstN    (rstN),
      .setIn   (cplSet[c]),
      .clrStb  (busWrEn && (busAddr == ADDR_W'(int'(REG_CPL0) + c))),
      .clrData (busWrData[CPL_W-1:0]),
      .q       (cplQ[c])
    );
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      REG_POL:                busRdData[NUM_EVT-1:0] = polQ;
      REG_EN_SET, REG_EN_CLR: busRdData[NUM_EVT-1:0] = enQ;
      REG_GRP_HI:             busRdData[NUM_EVT-1:0] = grpHiQ;
      REG_GRP_LO:             busRdData[NUM_EVT-1:0] = ~grpHiQ;
      REG_FLAG:               busRdData[NUM_EVT-1:0] = flagQ;
      REG_FIFO0:              busRdData[FIFO_W-1:0]  = fifoQ[0];
      REG_FIFO1:              busRdData[FIFO_W-1:0]  = fifoQ[1];
      REG_CPL0:               busRdData[CPL_W-1:0]   = cplQ[0];
      REG_CPL1:               busRdData[CPL_W-1:0]   = cplQ[1];
      REG_TRIG:               busRdData[NUM_EVT-1:0] = trigQ;
      REG_STATUS:             busRdData[2*CPL_W:0]   = {busy, cplQ[1], cplQ[0]};
      default:                busRdData = '0;
    endcase
    for (int l = 0; l < NUM_LANE; l++) begin
      if (busAddr == ADDR_W'(int'(REG_LVL0) + l)) busRdData[LANE_W-1:0] = levelQ[l*LANE_W +: LANE_W];
    end
  end

  // R12: the status word follows the completion register 0 bits one cycle after a set
  assert_status_mirror_R12: assert property (@(posedge clk) disable iff (!rstN)
    (|cplSet0) |=> ((cplQ[0] & $past(cplSet0)) == $past(cplSet0)));

endmodule

// File: rtl/evtCaptureTop.sv
module evtCaptureTop
  import evtPkg::*;
#(
  parameter int unsigned NUM_EVT     = 32,
  parameter int unsigned FIFO_W      = 8,
  parameter int unsigned CPL_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IDX_W       = $clog2(NUM_EVT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [BUS_W-1:0]   busWrData,
  output logic [BUS_W-1:0]   busRdData,
  input  logic [FIFO_W-1:0]  fifoSet0,
  input  logic [FIFO_W-1:0]  fifoSet1,
  input  logic [CPL_W-1:0]   cplSet0,
  input  logic [CPL_W-1:0]   cplSet1,
  output logic               hiValid,
  output logic [IDX_W-1:0]   hiId,
  input  logic               hiReady,
  output logic               loValid,
  output logic [IDX_W-1:0]   loId,
  input  logic               loReady
);

  evtStb_t            stb;
  logic [NUM_EVT-1:0] polQ, enQ, grpHiQ, trigQ, flagQ, levelQ;
  logic               busy;

  evtCtrl #(.NUM_EVT(NUM_EVT), .FIFO_W(FIFO_W), .CPL_W(CPL_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .fifoSet0  (fifoSet0),
    .fifoSet1  (fifoSet1),
    .cplSet0   (cplSet0),
    .cplSet1   (cplSet1),
    .stb       (stb),
    .polQ      (polQ),
    .enQ       (enQ),
    .grpHiQ    (grpHiQ),
    .trigQ     (trigQ),
    .flagQ     (flagQ),
    .levelQ    (levelQ),
    .busy      (busy)
  );

  evtDatapath #(.NUM_EVT(NUM_EVT), .SYNC_STAGES(SYNC_STAGES), .IW(IDX_W)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .evtIn   (evtIn),
    .stb     (stb),
    .wrData  (busWrData[NUM_EVT-1:0]),
    .hiReady (hiReady),
    .loReady (loReady),
    .hiValid (hiValid),
    .hiId    (hiId),
    .loValid (loValid),
    .loId    (loId),
    .polQ    (polQ),
    .enQ     (enQ),
    .grpHiQ  (grpHiQ),
    .trigQ   (trigQ),
    .flagQ   (flagQ),
    .levelQ  (levelQ),
    .busy    (busy)
  );

endmodule

// File: tb/test_evtCaptureTop.sv
`timescale 1ns/1ps
module test_evtCaptureTop;
  import evtPkg::*;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] evtIn;
  logic [3:0]  busAddr;
  logic        busWrEn;
  logic [31:0] busWrData;
  logic [31:0] busRdData;
  logic [7:0]  fifoSet0, fifoSet1, cplSet0, cplSet1;
  logic        hiValid, hiReady, loValid, loReady;
  logic [4:0]  hiId, loId;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] trigShadow = '0;
  logic [31:0] rdv;

  always #2 clk = ~clk;

  evtCaptureTop i_evtCaptureTop (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .fifoSet0(fifoSet0), .fifoSet1(fifoSet1),
    .cplSet0(cplSet0), .cplSet1(cplSet1), .hiValid(hiValid), .hiId(hiId), .hiReady(hiReady),
    .loValid(loValid), .loId(loId), .loReady(loReady)
  );

  typedef struct packed {
    logic [31:0] trig;
    logic [31:0] en;
    logic [31:0] hi;
    logic        hiV;
    logic [4:0]  hiN;
    logic        loV;
    logic [4:0]  loN;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0011, 32'hFFFF_FFFF, 32'h0000_0010, 1'b1, 5'd4,  1'b0, 5'd0},
    '{32'h0000_0011, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 5'd0,  1'b1, 5'd0},
    '{32'h8100_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 5'd24, 1'b0, 5'd0},
    '{32'h0000_0006, 32'h0000_0004, 32'h0000_0000, 1'b0, 5'd0,  1'b1, 5'd2},
    '{32'h0000_00F0, 32'h0000_0000, 32'h0000_0000, 1'b0, 5'd0,  1'b0, 5'd0},
    '{32'hA000_0000, 32'hF000_0000, 32'h2000_0000, 1'b1, 5'd29, 1'b0, 5'd0},
    '{32'h0003_0000, 32'h0002_0000, 32'h0001_0000, 1'b0, 5'd0,  1'b1, 5'd17}
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic trigToggle(input logic [31:0] m);
    trigShadow = trigShadow ^ m;
    wr(REG_TRIG, trigShadow);
  endtask

  task automatic drain();
    wr(REG_EN_SET, 32'hFFFF_FFFF);
    hiReady = 1'b1; loReady = 1'b1;
    tick(40);
    hiReady = 1'b0; loReady = 1'b0;
    wr(REG_EN_CLR, 32'hFFFF_FFFF);
    wr(REG_GRP_LO, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; evtIn = '0; busAddr = '0; busWrEn = 1'b0; busWrData = '0;
    fifoSet0 = '0; fifoSet1 = '0; cplSet0 = '0; cplSet1 = '0;
    hiReady = 1'b0; loReady = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(1);

    // R13 reset state
    rd(REG_POL, rdv);    chk("R13 R1 polarity after reset", rdv, 32'h0);
    rd(REG_EN_SET, rdv); chk("R13 enables after reset", rdv, 32'h0);
    rd(REG_GRP_HI, rdv); chk("R13 R4 urgent mask after reset", rdv, 32'h0);
    rd(REG_FLAG, rdv);   chk("R13 flags after reset", rdv, 32'h0);
    rd(REG_STATUS, rdv); chk("R13 status after reset", rdv, 32'h0);
    rd(REG_FIFO0, rdv);  chk("R13 fifo0 after reset", rdv, 32'h0);
    chk("R13 valids after reset", {30'b0, hiValid, loValid}, 32'h0);

    // vector table: R6, R5, R11 under several masks
    for (int v = 0; v < NV; v++) begin
      wr(REG_EN_CLR, 32'hFFFF_FFFF);
      wr(REG_GRP_LO, 32'hFFFF_FFFF);
      wr(REG_GRP_HI, VECS[v].hi);
      wr(REG_EN_SET, VECS[v].en);
      trigToggle(VECS[v].trig);
      chk($sformatf("R6 vec%0d hiValid", v), {31'b0, hiValid}, {31'b0, VECS[v].hiV});
      if (VECS[v].hiV) chk($sformatf("R6 vec%0d hiId", v), {27'b0, hiId}, {27'b0, VECS[v].hiN});
      chk($sformatf("R6 vec%0d loValid", v), {31'b0, loValid}, {31'b0, VECS[v].loV});
      if (VECS[v].loV) chk($sformatf("R6 vec%0d loId", v), {27'b0, loId}, {27'b0, VECS[v].loN});
      rd(REG_FLAG, rdv);
      chk($sformatf("R5 R11 vec%0d flags", v), rdv, VECS[v].trig);
      drain();
    end
    rd(REG_FLAG, rdv); chk("R7 flags empty after drain", rdv, 32'h0);
    rd(REG_TRIG, rdv); chk("R11 trigger readback", rdv, trigShadow);

    // R2 latency of a hardware rising edge
    wr(REG_EN_SET, 32'h0000_0008);
    evtIn[3] = 1'b1;
    tick(2);
    chk("R2 no valid before third edge", {31'b0, loValid}, 32'h0);
    tick(1);
    chk("R2 valid on third edge", {31'b0, loValid}, 32'h1);
    chk("R2 id of hardware event", {27'b0, loId}, 32'd3);
    loReady = 1'b1; tick(1); loReady = 1'b0;
    chk("R7 accept clears valid", {31'b0, loValid}, 32'h0);
    rd(REG_FLAG, rdv); chk("R7 accept clears flag", rdv, 32'h0);

    // R1 falling polarity
    wr(REG_POL, 32'h0000_0020);
    wr(REG_EN_SET, 32'h0000_0020);
    evtIn[5] = 1'b1;
    tick(4);
    rd(REG_FLAG, rdv); chk("R1 rising edge ignored on falling line", rdv, 32'h0);
    evtIn[5] = 1'b0;
    tick(3);
    chk("R1 falling edge offered", {27'b0, loValid, loId}, {27'b0, 1'b1, 5'd5});
    wr(REG_POL, 32'h0);
    drain();

    // R8 level lanes
    evtIn = 32'hA1B2_C3D4;
    tick(3);
    rd(REG_LVL0, rdv); chk("R8 lane0", rdv, 32'hD4);
    rd(REG_LVL1, rdv); chk("R8 lane1", rdv, 32'hC3);
    rd(REG_LVL2, rdv); chk("R8 lane2", rdv, 32'hB2);
    rd(REG_LVL3, rdv); chk("R8 lane3", rdv, 32'hA1);
    evtIn = '0;
    tick(3);
    drain();

    // R7 new edge during accepting cycle keeps the flag
    wr(REG_EN_SET, 32'h0000_0040);
    trigToggle(32'h0000_0040);
    chk("R7 setup offer", {27'b0, loValid, loId}, {27'b0, 1'b1, 5'd6});
    loReady = 1'b1;
    trigToggle(32'h0000_0040);
    loReady = 1'b0;
    rd(REG_FLAG, rdv); chk("R7 flag survives same-cycle edge", rdv & 32'h40, 32'h40);
    chk("R7 still offered", {27'b0, loValid, loId}, {27'b0, 1'b1, 5'd6});
    loReady = 1'b1; tick(1); loReady = 1'b0;
    chk("R7 second accept clears", {31'b0, loValid}, 32'h0);
    drain();

    // R3 enable set/clear, write zero ignored
    wr(REG_EN_SET, 32'h0000_000F);
    wr(REG_EN_SET, 32'h0);
    rd(REG_EN_SET, rdv); chk("R3 zero to set ignored", rdv, 32'h0F);
    wr(REG_EN_CLR, 32'h0);
    rd(REG_EN_CLR, rdv); chk("R3 zero to clear ignored", rdv, 32'h0F);
    wr(REG_EN_CLR, 32'h3);
    rd(REG_EN_CLR, rdv); chk("R3 clear bits", rdv, 32'h0C);
    wr(REG_EN_CLR, 32'hFFFF_FFFF);

    // R4 group set/clear
    wr(REG_GRP_HI, 32'h0000_00F0);
    wr(REG_GRP_HI, 32'h0);
    rd(REG_GRP_HI, rdv); chk("R4 zero to urgent ignored", rdv, 32'hF0);
    wr(REG_GRP_LO, 32'h0000_0030);
    rd(REG_GRP_HI, rdv); chk("R4 move to normal", rdv, 32'hC0);
    rd(REG_GRP_LO, rdv); chk("R4 normal readback", rdv, 32'hFFFF_FF3F);
    wr(REG_GRP_LO, 32'hFFFF_FFFF);

    // R9 FIFO status
    fifoSet0 = 8'h5A; tick(1); fifoSet0 = '0;
    rd(REG_FIFO0, rdv); chk("R9 set from stub", rdv, 32'h5A);
    wr(REG_FIFO0, 32'h0A);
    rd(REG_FIFO0, rdv); chk("R9 write one clears", rdv, 32'h50);
    wr(REG_FIFO0, 32'h0);
    rd(REG_FIFO0, rdv); chk("R9 write zero ignored", rdv, 32'h50);
    fifoSet1 = 8'h01;
    wr(REG_FIFO1, 32'hFF);
    fifoSet1 = '0;
    rd(REG_FIFO1, rdv); chk("R9 set wins over clear", rdv, 32'h01);

    // R10 and R12 completion and status
    cplSet0 = 8'h81; cplSet1 = 8'h3C; tick(1); cplSet0 = '0; cplSet1 = '0;
    rd(REG_CPL0, rdv);   chk("R10 completion0 set", rdv, 32'h81);
    rd(REG_CPL1, rdv);   chk("R10 completion1 set", rdv, 32'h3C);
    rd(REG_STATUS, rdv); chk("R12 status mirror", rdv, 32'h0000_3C81);
    wr(REG_CPL0, 32'h01);
    rd(REG_STATUS, rdv); chk("R10 R12 clear reflected", rdv, 32'h0000_3C80);
    wr(REG_EN_SET, 32'h0000_0200);
    trigToggle(32'h0000_0200);
    rd(REG_STATUS, rdv); chk("R12 busy bit", rdv, 32'h0001_3C80);
    drain();
    rd(REG_STATUS, rdv); chk("R12 idle after drain", rdv, 32'h0000_3C80);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule